// File: doc/BRIEF.md
# Buck Converter PWM / Hysteretic Mode Controller

This block decides, once per switching cycle, whether a synchronous buck converter runs in fixed-frequency PWM or in light-load hysteretic operation. It then turns that decision into high-side and low-side gate enable requests. A phase-polarity comparator bit is sampled on a strobe. The strobe marks the end of low-side conduction, just before the high-side switch would turn on. A streak of same-sign samples moves the controller from one mode to the other. A sample of the opposite sign restarts the streak, so the mode cannot chatter when the load sits near the boundary.

In PWM mode the gates follow the modulator's high-side request, with the low side as its complement. In hysteretic mode the high side is on only during an inductor current pulse. The pulse is started by the output-below-lower-limit comparator and ended by the output-above-upper-limit comparator. Outside a pulse both switches stay off, so the low side behaves like a diode. A load-step droop comparator returns the controller to PWM on the next clock. A force-PWM input keeps it in PWM for as long as it is asserted.

Top module: `buck_mode_ctrl`

## Requirements
- R1: While `rst_n` is low or `chan_en` is low, the next clock leaves `hyst_mode` at 0 (PWM) and the streak cleared. While `chan_en` is low, both gate requests are 0.
- R2: Phase polarity is taken into account only in cycles where `cyc_sample` is 1. Changes of `phase_pos` in other cycles have no effect on the mode or on the streak.
- R3: In PWM (`hyst_mode`=0), the eighth consecutive sample with `phase_pos`=1 (positive phase node) sets `hyst_mode` to 1 at that clock edge.
- R4: In hysteretic mode (`hyst_mode`=1), the eighth consecutive sample with `phase_pos`=0 sets `hyst_mode` back to 0 at that clock edge.
- R5: A sample of the opposite sign clears the consecutive count. Seven samples, then one opposite sample, then seven samples again leave the mode unchanged.
- R6: In hysteretic mode, `load_droop`=1 sampled at a clock edge sets `hyst_mode` to 0 at that edge.
- R7: In hysteretic mode, `vout_low`=1 starts a pulse (`hs_gate_en`=1 from the next clock) and `vout_high`=1 ends it (`hs_gate_en`=0 from the next clock). When both are 1, `vout_high` wins.
- R8: In hysteretic mode `ls_gate_en` is always 0. Between pulses, and in the first cycle after entering hysteretic mode, both gate requests are 0.
- R9: While `force_pwm`=1, `hyst_mode` is 0 from the next clock and stays 0, whatever the phase samples.
- R10: In PWM mode with the channel enabled, `hs_gate_en` equals `pwm_hs_req` and `ls_gate_en` equals its inverse. The two requests are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low forces PWM and gates off |
| cyc_sample | input | 1 | One-cycle strobe at the end of low-side conduction |
| phase_pos | input | 1 | Phase comparator: 1 = phase node positive |
| force_pwm | input | 1 | Inhibit hysteretic operation |
| vout_low | input | 1 | Output at or below the hysteretic lower limit |
| vout_high | input | 1 | Output at or above the hysteretic upper limit |
| load_droop | input | 1 | Output dropped below the regulation level by a load step |
| pwm_hs_req | input | 1 | High-side request from the PWM modulator |
| hyst_mode | output | 1 | Current mode: 0 = PWM, 1 = hysteretic |
| hs_gate_en | output | 1 | High-side gate enable request |
| ls_gate_en | output | 1 | Low-side gate enable request |

## Verification
A corrupted streak count shows up at `hyst_mode` as a mode change that comes one or more samples early or late. It becomes visible at the strobe where the bench expects the eighth sample to take effect. A lost or stuck mode bit shows in the same cycle at the gate outputs. PWM follows `pwm_hs_req` with its complement, while hysteretic mode keeps the low side off. A wrong pulse state shows on `hs_gate_en` one clock after the limit comparator that should have set or cleared it.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

   typedef enum logic {
      MODE_PWM  = 1'b0,
      MODE_HYST = 1'b1
   } op_mode_e;

   // Polarity that argues for leaving the current mode
   function automatic logic leave_sign(input op_mode_e cur, input logic phase_is_pos);
      return (cur == MODE_HYST) ? ~phase_is_pos : phase_is_pos;
   endfunction

endpackage

// File: rtl/bmc_sync.sv
module bmc_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (WIDTH >= 1) else $error("bmc_sync: WIDTH must be at least 1");
      assert (STAGES >= 0 && STAGES <= 4) else $error("bmc_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bmc_streak.sv
module bmc_streak #(
   parameter int STREAK_LEN = 8,
   parameter int CNT_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sample,
   input  logic             toward,
   output logic             hit,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(STREAK_LEN - 1);
   localparam logic [CNT_W-1:0] SAT  = {CNT_W{1'b1}};

   initial begin
      assert (STREAK_LEN >= 2) else $error("bmc_streak: STREAK_LEN must be at least 2");
      assert ((1 << CNT_W) >= STREAK_LEN) else $error("bmc_streak: CNT_W too narrow");
   end

   assign hit = sample & toward & ~clear & (count == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (sample) begin
         if (!toward)           count <= '0;
         else if (hit)          count <= '0;
         else if (count != SAT) count <= count + 1'b1;
      end
   end

   // R2: no sample, no clear -> streak untouched
   a_r2_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample && !clear) |=> $stable(count));

   // R5: an opposite-sign sample restarts the streak
   a_r5_opposite_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !toward) |=> (count == '0));

endmodule

// File: rtl/bmc_mode_fsm.sv
module bmc_mode_fsm
   import buck_mode_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     force_pwm,
   input  logic     droop,
   input  logic     hit,
   output op_mode_e mode_q,
   output op_mode_e mode_d,
   output logic     streak_clr
);

   always_comb begin
      mode_d = mode_q;
      if (!en || force_pwm)                   mode_d = MODE_PWM;
      else if (mode_q == MODE_HYST && droop)  mode_d = MODE_PWM;
      else if (hit)                           mode_d = (mode_q == MODE_HYST) ? MODE_PWM : MODE_HYST;
   end

   assign streak_clr = ~en | force_pwm | ((mode_q == MODE_HYST) & droop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_PWM;
      else        mode_q <= mode_d;
   end

   // R1: disable returns to PWM
   a_r1_disable_pwm: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (mode_q == MODE_PWM));

   // R6: load droop leaves hysteretic mode on the next clock
   a_r6_droop_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode_q == MODE_HYST && droop) |=> (mode_q == MODE_PWM));

   // R9: forced PWM holds the mode
   a_r9_force_pwm: assert property (@(posedge clk) disable iff (!rst_n)
      (en && force_pwm) |=> (mode_q == MODE_PWM));

   // R3: entry to hysteretic mode only at a completed streak
   a_r3_entry_on_streak: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_q == MODE_HYST) |-> $past(hit));

endmodule

// File: rtl/bmc_hyst_pulse.sv
module bmc_hyst_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic stay_hyst,
   input  logic at_low,
   input  logic at_high,
   output logic pulse_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pulse_q <= 1'b0;
      else if (!stay_hyst) pulse_q <= 1'b0;
      else if (at_high)    pulse_q <= 1'b0;
      else if (at_low)     pulse_q <= 1'b1;
   end

   // R7: upper limit ends the pulse
   a_r7_end_at_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (stay_hyst && at_high) |=> !pulse_q);

   // R7: lower limit starts the pulse
   a_r7_start_at_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (stay_hyst && at_low && !at_high) |=> pulse_q);

endmodule

// File: rtl/bmc_gate_req.sv
module bmc_gate_req
   import buck_mode_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  op_mode_e mode_q,
   input  logic     pulse_q,
   input  logic     pwm_req,
   output logic     hs_en,
   output logic     ls_en
);

   always_comb begin
      hs_en = 1'b0;
      ls_en = 1'b0;
      if (en) begin
         if (mode_q == MODE_HYST) begin
            hs_en = pulse_q;
         end else begin
            hs_en = pwm_req;
            ls_en = ~pwm_req;
         end
      end
   end

   // R10: never both switches requested
   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));

   // R8: diode emulation keeps the low side off in hysteretic mode
   a_r8_ls_off_hyst: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_HYST) |-> !ls_en);

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
   import buck_mode_pkg::*;
#(
   parameter int STREAK_LEN  = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_en,
   input  logic cyc_sample,
   input  logic phase_pos,
   input  logic force_pwm,
   input  logic vout_low,
   input  logic vout_high,
   input  logic load_droop,
   input  logic pwm_hs_req,
   output logic hyst_mode,
   output logic hs_gate_en,
   output logic ls_gate_en
);

   localparam int CNT_W  = (STREAK_LEN > 1) ? $clog2(STREAK_LEN) : 1;
   localparam int CMP_W  = 5;

   initial begin
      assert (STREAK_LEN >= 2 && STREAK_LEN <= 256)
         else $error("buck_mode_ctrl: STREAK_LEN out of range");
   end

   logic [CMP_W-1:0] cmp_raw, cmp_s;
   logic             ph_s, frc_s, low_s, high_s, drp_s;

   assign cmp_raw = {phase_pos, force_pwm, vout_low, vout_high, load_droop};

   bmc_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_raw),
      .q     (cmp_s)
   );

   assign {ph_s, frc_s, low_s, high_s, drp_s} = cmp_s;

   op_mode_e         mode_q, mode_d;
   logic             streak_clr, streak_hit, toward;
   logic [CNT_W-1:0] streak_cnt;
   logic             pulse_q;

   assign toward = leave_sign(mode_q, ph_s);

   bmc_streak #(.STREAK_LEN(STREAK_LEN), .CNT_W(CNT_W)) u_streak (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (streak_clr),
      .sample (cyc_sample),
      .toward (toward),
      .hit    (streak_hit),
      .count  (streak_cnt)
   );

   bmc_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (chan_en),
      .force_pwm  (frc_s),
      .droop      (drp_s),
      .hit        (streak_hit),
      .mode_q     (mode_q),
      .mode_d     (mode_d),
      .streak_clr (streak_clr)
   );

   bmc_hyst_pulse u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .stay_hyst ((mode_q == MODE_HYST) && (mode_d == MODE_HYST)),
      .at_low    (low_s),
      .at_high   (high_s),
      .pulse_q   (pulse_q)
   );

   bmc_gate_req u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (chan_en),
      .mode_q  (mode_q),
      .pulse_q (pulse_q),
      .pwm_req (pwm_hs_req),
      .hs_en   (hs_gate_en),
      .ls_en   (ls_gate_en)
   );

   assign hyst_mode = (mode_q == MODE_HYST);

   // R8: the first cycle in hysteretic mode has both switches off
   a_r8_entry_both_off: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && $rose(hyst_mode)) |-> (!hs_gate_en && !ls_gate_en));

   // R4: leaving hysteretic mode needs a completed streak, droop, force or disable
   a_r4_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hyst_mode) |-> $past(streak_hit || streak_clr));

   // R1: disabled channel requests no gate
   a_r1_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> (!hs_gate_en && !ls_gate_en));

endmodule

// File: tb/buck_mode_ctrl_tb.sv
module buck_mode_ctrl_tb;

   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_en = 1'b0, cyc_sample = 1'b0, phase_pos = 1'b0, force_pwm = 1'b0;
   logic vout_low = 1'b0, vout_high = 1'b0, load_droop = 1'b0, pwm_hs_req = 1'b0;
   logic hyst_mode, hs_gate_en, ls_gate_en;

   always #10 clk = ~clk;   // 50 MHz

   buck_mode_ctrl #(.STREAK_LEN(N), .SYNC_STAGES(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cyc_sample(cyc_sample),
      .phase_pos(phase_pos), .force_pwm(force_pwm), .vout_low(vout_low),
      .vout_high(vout_high), .load_droop(load_droop), .pwm_hs_req(pwm_hs_req),
      .hyst_mode(hyst_mode), .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en)
   );

   typedef struct {
      logic  mode;
      logic  hs;
      logic  ls;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 0;

   // requirement-level model state
   logic m_hyst = 1'b0;
   int   m_cnt  = 0;
   logic m_pulse = 1'b0;

   // driver: predicts the state after the coming edge, pushes it, waits a cycle
   task automatic cyc(input string tag);
      exp_t e;
      logic nxt;
      logic toward;
      if (!rst_n || !chan_en || force_pwm || (m_hyst && load_droop)) begin
         m_hyst = 1'b0; m_cnt = 0; m_pulse = 1'b0;
      end else begin
         nxt = m_hyst;
         if (cyc_sample) begin
            toward = m_hyst ? !phase_pos : phase_pos;
            if (!toward)          m_cnt = 0;
            else if (m_cnt == N-1) begin nxt = !m_hyst; m_cnt = 0; end
            else                  m_cnt = m_cnt + 1;
         end
         if (nxt && m_hyst) begin
            if (vout_high)     m_pulse = 1'b0;
            else if (vout_low) m_pulse = 1'b1;
         end else begin
            m_pulse = 1'b0;
         end
         m_hyst = nxt;
      end
      e.mode = m_hyst;
      if (!chan_en)    begin e.hs = 1'b0;       e.ls = 1'b0; end
      else if (m_hyst) begin e.hs = m_pulse;    e.ls = 1'b0; end
      else             begin e.hs = pwm_hs_req; e.ls = !pwm_hs_req; end
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic samp(input logic pos, input string tag);
      cyc_sample = 1'b1; phase_pos = pos;
      cyc(tag);
      cyc_sample = 1'b0;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (hyst_mode !== e.mode || hs_gate_en !== e.hs || ls_gate_en !== e.ls) begin
               errors++;
               $display("FAIL %s: actual mode=%b hs=%b ls=%b expected mode=%b hs=%b ls=%b",
                        e.tag, hyst_mode, hs_gate_en, ls_gate_en, e.mode, e.hs, e.ls);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1: reset state
      idle(3, "R1 reset");
      rst_n = 1'b1;
      idle(2, "R1 disabled after reset");
      chan_en = 1'b1;

      // R10: PWM gates follow the modulator request
      pwm_hs_req = 1'b1; cyc("R10 hs on");
      pwm_hs_req = 1'b0; cyc("R10 ls on");
      pwm_hs_req = 1'b1; cyc("R10 hs on again");
      pwm_hs_req = 1'b0;

      // R5: 7 positive, one negative, 7 positive -> still PWM
      for (int i = 0; i < N-1; i++) samp(1'b1, "R5 first run");
      samp(1'b0, "R5 opposite sample");
      for (int i = 0; i < N-1; i++) samp(1'b1, "R5 second run");

      // R2: polarity toggling without strobe has no effect
      for (int i = 0; i < 6; i++) begin phase_pos = i[0]; cyc("R2 no strobe"); end
      phase_pos = 1'b0;
      idle(1, "R2 idle");

      // R3: eighth positive sample enters hysteretic; R8 first cycle both off
      samp(1'b1, "R3 eighth positive");
      idle(2, "R8 between pulses");

      // R7: pulse start and end
      vout_low = 1'b1; cyc("R7 lower limit");
      vout_low = 1'b0; idle(2, "R7 pulse held");
      vout_high = 1'b1; cyc("R7 upper limit");
      vout_high = 1'b0; idle(2, "R8 off after pulse");
      vout_low = 1'b1; vout_high = 1'b1; cyc("R7 upper wins");
      vout_high = 1'b0; cyc("R7 restart");
      vout_low = 1'b0; pwm_hs_req = 1'b1; cyc("R8 ignores pwm request");
      pwm_hs_req = 1'b0;

      // R4: negative streak broken once, then eight negatives -> PWM
      for (int i = 0; i < 5; i++) samp(1'b0, "R4 partial");
      samp(1'b1, "R5 break in hyst");
      for (int i = 0; i < N; i++) samp(1'b0, "R4 eight negatives");
      idle(2, "R4 back in PWM");

      // R6: droop in hysteretic mode
      for (int i = 0; i < N; i++) samp(1'b1, "R3 reenter");
      vout_low = 1'b1; cyc("R7 pulse before droop");
      vout_low = 1'b0; load_droop = 1'b1; cyc("R6 droop exit");
      load_droop = 1'b0; idle(2, "R6 stays PWM");
      load_droop = 1'b1; cyc("R6 droop ignored in PWM");
      load_droop = 1'b0;

      // R9: force in PWM blocks entry; force in hysteretic exits
      force_pwm = 1'b1;
      for (int i = 0; i < N+3; i++) samp(1'b1, "R9 forced PWM");
      force_pwm = 1'b0;
      for (int i = 0; i < N; i++) samp(1'b1, "R3 entry after force");
      force_pwm = 1'b1; cyc("R9 force exits hyst");
      force_pwm = 1'b0; idle(1, "R9 after release");

      // R1: disable while in hysteretic mode
      for (int i = 0; i < N; i++) samp(1'b1, "R3 entry before disable");
      chan_en = 1'b0; pwm_hs_req = 1'b1; cyc("R1 disable");
      idle(2, "R1 disabled gates off");
      chan_en = 1'b1; cyc("R1 reenabled in PWM");
      for (int i = 0; i < N-1; i++) samp(1'b1, "R1 streak cleared by disable");

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule